// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This unit performs the eight classic shift and rotate operations on an 8-, 16- or 32-bit operand held in the low bits of a 32-bit input. The operations are the logical shifts left and right, the arithmetic shifts left and right, the plain rotates left and right, and the rotates left and right through the carry flag. Each operation takes a variable count and reports the result together with updated carry, zero and sign flags.

An execution pipeline presents one operation per cycle with `in_valid`. The unit registers the result, so it appears on the outputs one clock later together with `out_valid`. The unit also receives the current zero and sign flags. When the masked count is zero, nothing changes, and the incoming flags are passed back unchanged.

Top module: `shrot_unit`

## Requirements
- R1: `size_in` selects the operand width: 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 selects 32 bits. Only `operand_in[W-1:0]` is used, and `result_out` bits at W and above are always 0.
- R2: `op_in` codes 0 (shift left), 2 (arithmetic shift left, same as 0) and 1 (logical shift right) fill the vacated bits with zeros. The carry flag is the last bit that leaves the operand. A count larger than W gives a result of 0 and a carry of 0.
- R3: `op_in` code 3 (arithmetic shift right) fills the vacated bits with bit W-1 of the operand. The carry flag is the last bit shifted out. A count of W or more gives all sign bits, and the carry equals the sign.
- R4: `op_in` codes 4 (rotate left) and 5 (rotate right) rotate by the count modulo W. The carry is bit 0 of the result for a left rotate and bit W-1 of the result for a right rotate.
- R5: `op_in` codes 6 (left) and 7 (right) rotate the W+1 bit ring formed by the carry above the operand, by the count modulo W+1. The new carry is the ring bit above the result.
- R6: Only the low 5 bits of `count_in` are used; bits 7:5 have no effect.
- R7: When the masked count is 0, the result is the operand at width W, and `carry_out`, `zero_out` and `sign_out` equal `carry_in`, `zero_in` and `sign_in`.
- R8: When the masked count is not 0, `zero_out` is 1 exactly when the W-bit result is 0, and `sign_out` equals result bit W-1.
- R9: A 32-bit right rotate by 16 swaps the upper and lower halves of the operand.
- R10: Outputs update on the clock edge after an input with `in_valid` high. `out_valid` is high in exactly those cycles. During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op_in | input | 3 | Operation code (see R2 to R5) |
| size_in | input | 2 | Operand width select |
| operand_in | input | 32 | Operand, low bits used |
| count_in | input | 8 | Shift or rotate count |
| carry_in | input | 1 | Incoming carry flag |
| zero_in | input | 1 | Incoming zero flag |
| sign_in | input | 1 | Incoming sign flag |
| out_valid | output | 1 | Result valid |
| result_out | output | 32 | Result, zero above the operand width |
| carry_out | output | 1 | Updated carry flag |
| zero_out | output | 1 | Updated zero flag |
| sign_out | output | 1 | Updated sign flag |

## Verification
The bench uses the default 5-bit count mask, so counts up to 31 can be applied. For 8- and 16-bit operands this reaches counts past the width, the wrap of a through-carry rotate at 9 and 17, and plain rotates by a whole multiple of the width. The reference model steps one bit at a time, so the modulo rules and the carry-past-width rules are derived from first principles rather than copied. Directed cases cover each of these corners, the swap of the two 16-bit halves, and masked counts of zero. A pseudo-random sweep covers every operation and width.

// File: rtl/shrot_unit.sv
module shrot_unit #(
  parameter int CNT_BITS = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [2:0]  op_in,
  input  logic [1:0]  size_in,
  input  logic [31:0] operand_in,
  input  logic [7:0]  count_in,
  input  logic        carry_in,
  input  logic        zero_in,
  input  logic        sign_in,
  output logic        out_valid,
  output logic [31:0] result_out,
  output logic        carry_out,
  output logic        zero_out,
  output logic        sign_out
);
  localparam logic [2:0] OP_SHL = 3'd0, OP_SHR = 3'd1, OP_SAL = 3'd2, OP_SAR = 3'd3,
                         OP_ROL = 3'd4, OP_ROR = 3'd5, OP_RCL = 3'd6, OP_RCR = 3'd7;

  logic [5:0]  c6, wv, rw, rc;
  logic [4:0]  top_i;
  logic [31:0] wmask, xw, xs, res, res_m;
  logic [32:0] ring, rot;
  logic [63:0] sh64;
  logic [65:0] sh66;
  logic        cf, zf, sf;

  assign c6 = 6'(count_in[CNT_BITS-1:0]);

  always_comb begin
    case (size_in)
      2'd0:    begin wv = 6'd8;  wmask = 32'h0000_00FF; xs = {{24{operand_in[7]}},  operand_in[7:0]};  end
      2'd1:    begin wv = 6'd16; wmask = 32'h0000_FFFF; xs = {{16{operand_in[15]}}, operand_in[15:0]}; end
      default: begin wv = 6'd32; wmask = 32'hFFFF_FFFF; xs = operand_in; end
    endcase
  end

  assign top_i = 5'(wv - 6'd1);
  assign xw    = operand_in & wmask;
  assign ring  = {1'b0, xw} | (33'd1 << wv);
  assign rw    = c6 & (wv - 6'd1);

  always_comb begin
    rc = c6;
    if (size_in == 2'd0) begin
      if (c6 >= 6'd27)      rc = c6 - 6'd27;
      else if (c6 >= 6'd18) rc = c6 - 6'd18;
      else if (c6 >= 6'd9)  rc = c6 - 6'd9;
    end else if (size_in == 2'd1) begin
      if (c6 >= 6'd17) rc = c6 - 6'd17;
    end
  end

  always_comb begin
    res  = xw;
    cf   = carry_in;
    sh64 = '0;
    sh66 = '0;
    rot  = '0;
    case (op_in)
      OP_SHL, OP_SAL: begin
        sh64 = {32'd0, xw} << c6;
        res  = sh64[31:0];
        cf   = sh64[wv];
      end
      OP_SHR: begin
        sh64 = {xw, 32'd0} >> c6;
        res  = sh64[63:32];
        cf   = sh64[31];
      end
      OP_SAR: begin
        sh64 = 64'($signed({xs, 32'd0}) >>> c6);
        res  = sh64[63:32];
        cf   = sh64[31];
      end
      OP_ROL: begin
        sh64 = {32'd0, xw} << rw;
        res  = sh64[31:0] | 32'(sh64 >> wv);
      end
      OP_ROR: begin
        sh64 = {xw, 32'd0} >> rw;
        res  = sh64[63:32] | (sh64[31:0] >> (6'd32 - wv));
      end
      OP_RCL, OP_RCR: begin
        if (carry_in) sh66 = '0;
        if (op_in == OP_RCL) begin
          sh66 = {33'd0, (carry_in ? ring : {1'b0, xw})} << rc;
          rot  = sh66[32:0] | 33'(sh66 >> (wv + 6'd1));
        end else begin
          sh66 = {(carry_in ? ring : {1'b0, xw}), 33'd0} >> rc;
          rot  = sh66[65:33] | (sh66[32:0] >> (6'd32 - wv));
        end
        res = rot[31:0];
        cf  = rot[wv];
      end
      default: ;
    endcase
    res_m = res & wmask;
    if (op_in == OP_ROL) cf = res_m[0];
    if (op_in == OP_ROR) cf = res_m[top_i];
    zf = (res_m == 32'd0);
    sf = res_m[top_i];
    if (c6 == 6'd0) begin
      res_m = xw;
      cf    = carry_in;
      zf    = zero_in;
      sf    = sign_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      result_out <= '0;
      carry_out  <= 1'b0;
      zero_out   <= 1'b0;
      sign_out   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result_out <= res_m;
        carry_out  <= cf;
        zero_out   <= zf;
        sign_out   <= sf;
      end
    end
  end

  a_r10_valid: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid);
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid);
  a_r1_byte_upper: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && size_in == 2'd0 |=> result_out[31:8] == 24'd0);
  a_r2_shr_sign: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_in == OP_SHR && c6 != 6'd0 |=> !sign_out);
  a_r2_shl_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (op_in == OP_SHL || op_in == OP_SAL) && c6 != 6'd0 |=> !result_out[0]);
  a_r3_sar_sign: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_in == OP_SAR && c6 != 6'd0 |=> sign_out == $past(xs[31]));
  a_r4_rot_ones: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (op_in == OP_ROL || op_in == OP_ROR) |=> $countones(result_out) == $countones($past(xw)));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && c6 == 6'd0 |=> carry_out == $past(carry_in) && zero_out == $past(zero_in) && sign_out == $past(sign_in));
endmodule

// File: tb/shrot_unit_test.sv
module shrot_unit_test;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [2:0] op_in = '0;
  logic [1:0] size_in = '0;
  logic [31:0] operand_in = '0;
  logic [7:0] count_in = '0;
  logic carry_in = 1'b0, zero_in = 1'b0, sign_in = 1'b0;
  logic out_valid, carry_out, zero_out, sign_out;
  logic [31:0] result_out;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [34:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  shrot_unit uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_in(op_in), .size_in(size_in),
    .operand_in(operand_in), .count_in(count_in), .carry_in(carry_in), .zero_in(zero_in),
    .sign_in(sign_in), .out_valid(out_valid), .result_out(result_out), .carry_out(carry_out),
    .zero_out(zero_out), .sign_out(sign_out));

  function automatic logic [34:0] model(input logic [2:0] op, input logic [1:0] sz,
      input logic [31:0] x, input logic [7:0] cnt, input logic ci, zi, si);
    int w;
    logic [31:0] m, v;
    logic c, b;
    int n;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    v = x & m;
    c = ci;
    n = int'(cnt[4:0]);
    if (n == 0) return {v, ci, zi, si};
    for (int i = 0; i < n; i++) begin
      case (op)
        3'd0, 3'd2: begin c = v[w-1]; v = (v << 1) & m; end
        3'd1: begin c = v[0]; v = v >> 1; end
        3'd3: begin c = v[0]; b = v[w-1]; v = (v >> 1) | (32'(b) << (w-1)); end
        3'd4: begin b = v[w-1]; v = ((v << 1) | 32'(b)) & m; c = b; end
        3'd5: begin b = v[0]; v = (v >> 1) | (32'(b) << (w-1)); c = b; end
        3'd6: begin b = v[w-1]; v = ((v << 1) | 32'(c)) & m; c = b; end
        default: begin b = v[0]; v = (v >> 1) | (32'(c) << (w-1)); c = b; end
      endcase
    end
    return {v, c, (v == 32'd0), v[w-1]};
  endfunction

  task automatic send(input logic [2:0] op, input logic [1:0] sz, input logic [31:0] x,
      input logic [7:0] cnt, input logic ci, zi, si, input string tag);
    @(posedge clk); #2;
    in_valid = 1'b1; op_in = op; size_in = sz; operand_in = x; count_in = cnt;
    carry_in = ci; zero_in = zi; sign_in = si;
    exp_q.push_back(model(op, sz, x, cnt, ci, zi, si));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R10 out_valid with nothing pending: actual=1 expected=0");
      end else begin
        logic [34:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({result_out, carry_out, zero_out, sign_out} !== e) begin
          failures++;
          $display("FAIL %s: actual res=%h cf=%b zf=%b sf=%b expected res=%h cf=%b zf=%b sf=%b",
            t, result_out, carry_out, zero_out, sign_out, e[34:3], e[2], e[1], e[0]);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({out_valid, result_out, carry_out, zero_out, sign_out} !== '0) begin
      failures++;
      $display("FAIL R10 reset state: actual=%h expected=0", {out_valid, result_out, carry_out, zero_out, sign_out});
    end
    rst_n = 1'b1;
    send(3'd0, 2'd0, 32'hFFFF_FF81, 8'd1, 1'b0, 1'b0, 1'b0, "R2 shl8 by1 (R1 upper masked)");
    send(3'd2, 2'd1, 32'h0000_8001, 8'd17, 1'b1, 1'b0, 1'b0, "R2 sal16 past width");
    send(3'd1, 2'd2, 32'h1234_5678, 8'd4, 1'b0, 1'b0, 1'b0, "R2 shr32 by4");
    send(3'd1, 2'd0, 32'h0000_00FF, 8'd9, 1'b1, 1'b0, 1'b0, "R2 shr8 past width");
    send(3'd3, 2'd0, 32'h0000_0080, 8'd3, 1'b0, 1'b0, 1'b0, "R3 sar8 by3");
    send(3'd3, 2'd1, 32'h0000_8000, 8'd20, 1'b0, 1'b0, 1'b0, "R3 sar16 past width");
    send(3'd4, 2'd0, 32'h0000_0081, 8'd1, 1'b0, 1'b0, 1'b0, "R4 rol8 by1");
    send(3'd4, 2'd0, 32'h0000_0081, 8'd8, 1'b0, 1'b0, 1'b0, "R4 rol8 by width");
    send(3'd5, 2'd1, 32'h0000_0001, 8'd1, 1'b0, 1'b0, 1'b0, "R4 ror16 by1 (R8 sign)");
    send(3'd5, 2'd2, 32'h1234_5678, 8'd16, 1'b0, 1'b0, 1'b0, "R9 ror32 half swap");
    send(3'd6, 2'd0, 32'h0000_0080, 8'd1, 1'b0, 1'b0, 1'b0, "R5 rcl8 to zero (R8 zero flag)");
    send(3'd7, 2'd0, 32'h0000_0001, 8'd9, 1'b1, 1'b0, 1'b0, "R5 rcr8 full ring");
    send(3'd6, 2'd1, 32'h0000_4000, 8'd18, 1'b1, 1'b0, 1'b0, "R5 rcl16 wrap");
    send(3'd7, 2'd2, 32'h8000_0001, 8'd31, 1'b1, 1'b0, 1'b0, "R5 rcr32 by31");
    send(3'd1, 2'd2, 32'h0000_00F0, 8'h21, 1'b0, 1'b0, 1'b0, "R6 count upper bits ignored");
    send(3'd0, 2'd0, 32'hABCD_1234, 8'h20, 1'b1, 1'b1, 1'b1, "R7 masked zero count");
    send(3'd6, 2'd2, 32'h0000_0000, 8'h00, 1'b0, 1'b1, 1'b0, "R7 zero count rcl");
    idle();
    repeat (2) @(posedge clk);
    lfsr = 32'hACE1_1234;
    for (int i = 0; i < 240; i++) begin
      logic [2:0] op;
      string t;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      op = lfsr[2:0];
      t = (op == 3'd3) ? "R3 sweep" : (op >= 3'd6) ? "R5 sweep" : (op >= 3'd4) ? "R4 sweep" : "R2 sweep";
      send(op, lfsr[4:3], lfsr ^ {lfsr[15:0], lfsr[31:16]}, lfsr[12:5], lfsr[13], lfsr[14], lfsr[15], t);
      if (lfsr[20:18] == 3'd0) idle();
    end
    idle();
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (exp_q.size() != 0 || out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R10 drain: actual pending=%0d valid=%b expected pending=0 valid=0", exp_q.size(), out_valid);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule